// File: doc/BRIEF.md
# Configurable Pin Capture Cell

This block sits between a group of chip pins and the programmable logic array. In the input direction, each pin value either goes straight through to the array or passes through a storage element first. One configuration input sets what that storage element is. It can be an edge-triggered register that captures on a rising edge of a dedicated capture clock. It can also be a latch that is transparent while the capture clock is high. The capture clock is distributed from the global cell. It is not formed by local logic.

The whole design runs in one system clock domain. The capture clock arrives as a level and is sampled every system cycle. In edge mode the cell captures the pin when the sampled capture clock changes from low to high. In level mode the stored value follows the pin on every cycle in which the capture clock is high. Every output is registered.

In the output direction, each pin can be driven from one of four logic-cell signals: A, B, C or the register output Q. A per-bit output enable gates this drive. The tri-state is modelled as a separate data output and enable output. A released pin drives 0 on its data output, and the cell then acts as a pure input. All mode and select inputs are static configuration.

Top module: `pin_capture_cell`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `array_out`, `pad_out` and `pad_oe` are all 0. The stored value is also 0.
- R2: In edge mode (`level_mode`=0), the pin value is captured in a cycle where `cap_clk` is 1 and was 0 in the previous cycle, or was reset. With `use_raw`=0, the captured value shows on `array_out` one cycle later.
- R3: In edge mode, the stored value does not change in any cycle without such a low-to-high transition. This includes cycles where `cap_clk` stays high while the pin changes.
- R4: In level mode (`level_mode`=1), the stored value takes the pin value in every cycle where `cap_clk` is 1. With `use_raw`=0 it shows on `array_out` one cycle later.
- R5: In level mode, the stored value holds in every cycle where `cap_clk` is 0.
- R6: With `use_raw`=1, `array_out` equals the pin value of the previous cycle, whatever the storage is doing.
- R7: For each bit whose enable is 1, `pad_out` one cycle later equals the signal picked by `src_sel`. The encoding is 0=A, 1=B, 2=C, 3=Q.
- R8: `pad_oe` is the per-bit output enable delayed by one cycle. A bit whose enable was 0 drives `pad_out` 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| level_mode | input | 1 | Storage type: 0 edge register, 1 high-transparent latch |
| use_raw | input | 1 | 1 sends the pin straight to the array, 0 sends the stored value |
| cap_clk | input | 1 | Capture clock level from the global cell |
| pin_in | input | W | Pin values seen by the cell |
| array_out | output | W | Registered value presented to the logic array |
| src_sel | input | 2 | Drive source: 0=A, 1=B, 2=C, 3=Q |
| sig_a | input | W | Logic-cell signal A |
| sig_b | input | W | Logic-cell signal B |
| sig_c | input | W | Logic-cell signal C |
| sig_q | input | W | Logic-cell register output Q |
| oe | input | W | Per-bit output enable |
| pad_out | output | W | Registered pin drive value, 0 when released |
| pad_oe | output | W | Registered pin drive enable |

## Verification
The assertions check the storage rules on every cycle:
- In edge mode the stored value holds unless there is a low-to-high transition.
- In level mode the stored value holds while the capture clock is low and follows the pin while it is high.
- The raw path, the released drive and the delayed enable are also checked each cycle.

Only the bench scenarios can show the rest:
- Reset values.
- Correct source selection across all four encodings.
- That a long high phase in edge mode captures exactly once.
- How mode changes behave part way through a run against a reference model.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2,
    SRC_Q = 2'd3
  } drive_src_e;
endpackage

// File: rtl/pcc_store.sv
module pcc_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic         cap_clk,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] store_q,
  output logic [W-1:0] store_nx
);
  logic cap_prev_q;
  logic capture;

  // Edge mode captures on a sampled low-to-high change; level mode on high.
  always_comb begin
    if (level_mode) capture = cap_clk;
    else            capture = cap_clk & ~cap_prev_q;
    store_nx = capture ? pin_in : store_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_prev_q <= 1'b0;
      store_q    <= '0;
    end else begin
      cap_prev_q <= cap_clk;
      store_q    <= store_nx;
    end
  end

  p_edge_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && cap_clk && !cap_prev_q) |=> store_q == $past(pin_in));
  p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && !(cap_clk && !cap_prev_q)) |=> $stable(store_q));
  p_level_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (level_mode && cap_clk) |=> store_q == $past(pin_in));
  p_level_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (level_mode && !cap_clk) |=> $stable(store_q));
endmodule

// File: rtl/pcc_drive.sv
module pcc_drive
  import pcc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   src_sel,
  input  logic [W-1:0] sig_a,
  input  logic [W-1:0] sig_b,
  input  logic [W-1:0] sig_c,
  input  logic [W-1:0] sig_q,
  input  logic [W-1:0] oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  drive_src_e sel;
  assign sel = drive_src_e'(src_sel);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic pick;
    always_comb begin
      unique case (sel)
        SRC_A:   pick = sig_a[i];
        SRC_B:   pick = sig_b[i];
        SRC_C:   pick = sig_c[i];
        default: pick = sig_q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_out[i] <= 1'b0;
        pad_oe[i]  <= 1'b0;
      end else begin
        pad_out[i] <= oe[i] & pick;
        pad_oe[i]  <= oe[i];
      end
    end

    p_released_r8: assert property (@(posedge clk) disable iff (rst)
      !oe[i] |=> !pad_out[i] && !pad_oe[i]);
  end
endmodule

// File: rtl/pin_capture_cell.sv
module pin_capture_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         level_mode,
  input  logic         use_raw,
  input  logic         cap_clk,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] array_out,
  input  logic [1:0]   src_sel,
  input  logic [W-1:0] sig_a,
  input  logic [W-1:0] sig_b,
  input  logic [W-1:0] sig_c,
  input  logic [W-1:0] sig_q,
  input  logic [W-1:0] oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] store_q;
  logic [W-1:0] store_nx;

  pcc_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .level_mode(level_mode), .cap_clk(cap_clk),
    .pin_in(pin_in), .store_q(store_q), .store_nx(store_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) array_out <= '0;
    else     array_out <= use_raw ? pin_in : store_nx;
  end

  p_raw_path_r6: assert property (@(posedge clk) disable iff (rst)
    use_raw |=> array_out == $past(pin_in));
  p_stored_path_r2: assert property (@(posedge clk) disable iff (rst)
    !use_raw |=> array_out == store_q);

  pcc_drive #(.W(W)) u_drive (
    .clk(clk), .rst(rst), .src_sel(src_sel), .sig_a(sig_a), .sig_b(sig_b),
    .sig_c(sig_c), .sig_q(sig_q), .oe(oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );
endmodule

// File: tb/pin_capture_cell_bench.sv
module pin_capture_cell_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         level_mode, use_raw, cap_clk;
  logic [W-1:0] pin_in, array_out, sig_a, sig_b, sig_c, sig_q, oe, pad_out, pad_oe;
  logic [1:0]   src_sel;

  int n_tests = 0;
  int n_fail  = 0;

  logic         m_prev;
  logic [W-1:0] m_store, m_arr, m_pad, m_oe;

  always #2 clk = ~clk;

  pin_capture_cell #(.W(W)) u_pin_capture_cell (
    .clk(clk), .rst(rst), .level_mode(level_mode), .use_raw(use_raw),
    .cap_clk(cap_clk), .pin_in(pin_in), .array_out(array_out),
    .src_sel(src_sel), .sig_a(sig_a), .sig_b(sig_b), .sig_c(sig_c),
    .sig_q(sig_q), .oe(oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [W-1:0] pick_src(input logic [1:0] s);
    case (s)
      2'd0: return sig_a;
      2'd1: return sig_b;
      2'd2: return sig_c;
      default: return sig_q;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance the model using inputs held across the edge, then compare.
  task automatic step();
    string tag;
    logic cap_now;
    @(posedge clk);
    cap_now = level_mode ? cap_clk : (cap_clk & ~m_prev);
    if (level_mode) tag = cap_clk ? "R4" : "R5";
    else            tag = cap_now ? "R2" : "R3";
    if (cap_now) m_store = pin_in;
    m_prev = cap_clk;
    m_arr  = use_raw ? pin_in : m_store;
    if (use_raw) tag = "R6";
    m_pad  = oe & pick_src(src_sel);
    m_oe   = oe;
    #1;
    check(tag, array_out, m_arr);
    check("R7", pad_out, m_pad);
    check("R8", pad_oe, m_oe);
    @(negedge clk);
  endtask

  task automatic rand_drive();
    pin_in  = W'($urandom);
    sig_a   = W'($urandom);
    sig_b   = W'($urandom);
    sig_c   = W'($urandom);
    sig_q   = W'($urandom);
    oe      = W'($urandom);
    src_sel = 2'($urandom);
    cap_clk = 1'($urandom);
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; level_mode = 1'b0; use_raw = 1'b0; cap_clk = 1'b0;
    pin_in = 8'hA5; sig_a = '1; sig_b = '1; sig_c = '1; sig_q = '1;
    oe = '1; src_sel = 2'd0;
    repeat (3) @(negedge clk);
    check("R1", array_out, '0);
    check("R1", pad_out, '0);
    check("R1", pad_oe, '0);
    m_prev = 1'b0; m_store = '0;
    rst = 1'b0; oe = '0; cap_clk = 1'b0;
    step();
    check("R1", array_out, '0);

    // R2/R3: one capture only during a long high phase in edge mode.
    level_mode = 1'b0;
    pin_in = 8'h3C; cap_clk = 1'b1; step();
    check("R2", array_out, 8'h3C);
    for (int k = 0; k < 4; k++) begin
      pin_in = 8'h10 + 8'(k); step();
    end
    check("R3", array_out, 8'h3C);
    cap_clk = 1'b0; pin_in = 8'hEE; step();
    check("R3", array_out, 8'h3C);

    // R4/R5: level mode follows while high, holds while low.
    level_mode = 1'b1; cap_clk = 1'b1;
    pin_in = 8'h55; step(); pin_in = 8'h66; step();
    check("R4", array_out, 8'h66);
    cap_clk = 1'b0; pin_in = 8'h77; step();
    check("R5", array_out, 8'h66);

    // R6: raw path.
    use_raw = 1'b1; pin_in = 8'h9A; step();
    check("R6", array_out, 8'h9A);

    // R7/R8: every source encoding with all enables, then released.
    use_raw = 1'b0;
    sig_a = 8'h11; sig_b = 8'h22; sig_c = 8'h44; sig_q = 8'h88; oe = '1;
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s); step();
    end
    oe = '0; step();
    check("R8", pad_out, '0);

    // Random phases with changing configuration.
    for (int blk = 0; blk < 40; blk++) begin
      level_mode = 1'($urandom);
      use_raw    = 1'($urandom);
      for (int c = 0; c < 50; c++) begin
        rand_drive();
        step();
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule